// File: doc/BRIEF.md
# Linear-to-Physical Page Translation Buffer

This block turns a 20-bit linear page number (the upper bits of a 32-bit linear address, with 4-KByte pages) into a 20-bit physical page frame. Three structures sit in front of a two-level table in memory. The first is a 128-entry direct-mapped main array. The second is an 8-entry fully associative victim buffer, which catches entries pushed out of the main array. The third is a 4-entry fully associative cache of directory entries, so that a walk whose directory entry is cached needs only one memory read.

A requester presents a lookup for one cycle while `busy` is low. A hit in the main array or in the victim buffer answers on the next clock edge. A victim hit also exchanges that entry with the one that holds its slot in the main array. When both miss, the block walks the tables through a read port, raises `busy`, and answers when the refill completes. Software raises `flush` after changing the directory base, and all three structures are emptied.

The controller has three states. `ST_IDLE` accepts lookups. `ST_DIR` reads a directory entry. `ST_PTE` reads a page table entry. From `ST_IDLE`, a miss in both arrays moves to `ST_DIR` when the directory cache misses, and to `ST_PTE` when it hits. `ST_DIR` moves to `ST_PTE` on the read reply. `ST_PTE` returns to `ST_IDLE` on its reply. A `flush` sends any state to `ST_IDLE`.

Top module: `page_xlate`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_req_valid` are 0.
- R2: A lookup accepted at a clock edge that hits the main array drives `resp_valid` from that same edge, with `resp_src`=0 and the stored frame, and issues no memory read.
- R3: The main array slot is chosen by page-number bits [6:0], and bits [19:7] are the tag. Pages with different low bits are held at the same time, while pages sharing the low bits conflict.
- R4: When a walk refills a main slot that holds a valid entry, that entry moves to the victim buffer. A later lookup of that page answers from the accept edge with `resp_src`=1 and no memory read.
- R5: On a victim hit, the found entry takes the main slot and the displaced main entry takes its victim slot. A page is never held twice in the victim buffer.
- R6: The victim buffer replaces its oldest inserted entry first, so the ninth displacement discards the first. Swaps do not change the age order.
- R7: When the directory cache misses, the walk reads the word at {base_pfn, vpn[19:10], 2'b00}. It then reads {dir_word[31:12], vpn[9:0], 2'b00} and returns pte_word[31:12] with `resp_src`=3, after exactly two reads.
- R8: When the directory entry is cached, the walk makes exactly one read (to the page table) and returns `resp_src`=2.
- R9: `busy` is high from the edge after a missing lookup is accepted until the edge that raises `resp_valid`. A lookup presented while `busy` is high is ignored and changes no stored entry.
- R10: A `flush` empties the main array, the victim buffer and the directory cache in one cycle.
- R11: The directory cache holds the four most recently filled directory entries and replaces them in fill order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all translation structures |
| base_pfn | input | 20 | Frame of the page directory |
| req_valid | input | 1 | Lookup request, taken when busy is low |
| req_vpn | input | 20 | Linear page number to translate |
| busy | output | 1 | A table walk is in progress |
| resp_valid | output | 1 | Translation result valid |
| resp_pfn | output | 20 | Physical page frame |
| resp_src | output | 2 | 0 main hit, 1 victim hit, 2 one-read walk, 3 two-read walk |
| mem_req_valid | output | 1 | Read request, held until the reply |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read reply valid |
| mem_rsp_data | input | 32 | Read reply word |

## Verification
Counting from the edge that accepts a lookup, a main or victim hit answers at that edge. With the bench memory replying on the second cycle of each request, a one-read walk answers two edges later and a two-read walk answers four edges later. Each expected item carries the cycle it is due in, and the monitor compares the cycle of every response against it as well as the frame and source. The driver also counts the memory reads made for each lookup, and responses that arrive with nothing expected are counted as failures, which catches lookups that should have been ignored.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFF_W  = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIR  = 2'd1,
        ST_PTE  = 2'd2
    } walk_state_t;

    typedef enum logic [1:0] {
        SRC_MAIN   = 2'd0,
        SRC_VICTIM = 2'd1,
        SRC_WALK1  = 2'd2,
        SRC_WALK2  = 2'd3
    } hit_src_t;
endpackage

// File: rtl/xlate_main_array.sv
`timescale 1ns/1ps
module xlate_main_array #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned TAG_W = 13,
    parameter int unsigned PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PFN_W-1:0] rd_pfn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PFN_W-1:0] pfn_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_pfn   = pfn_q[rd_idx];

    assert_flush_clears_main_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
endmodule

// File: rtl/xlate_victim.sv
`timescale 1ns/1ps
module xlate_victim #(
    parameter int unsigned N     = 8,
    parameter int unsigned VPN_W = 20,
    parameter int unsigned PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] srch_vpn,
    output logic             hit,
    output logic [$clog2(N)-1:0] hit_slot,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic             swp_en,
    input  logic [$clog2(N)-1:0] swp_slot,
    input  logic             swp_valid,
    input  logic [VPN_W-1:0] swp_vpn,
    input  logic [PFN_W-1:0] swp_pfn
);
    localparam int unsigned PTR_W = $clog2(N);

    logic [N-1:0]     vld_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [PTR_W-1:0] old_q;
    logic [N-1:0]     match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == srch_vpn);
    end

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        hit_pfn  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = PTR_W'(i);
                hit_pfn  = pfn_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            old_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
            old_q <= '0;
        end else if (ins_en) begin
            vld_q[old_q] <= 1'b1;
            old_q <= (old_q == PTR_W'(N - 1)) ? '0 : old_q + 1'b1;
        end else if (swp_en) begin
            vld_q[swp_slot] <= swp_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            vpn_q[old_q] <= ins_vpn;
            pfn_q[old_q] <= ins_pfn;
        end else if (swp_en) begin
            vpn_q[swp_slot] <= swp_vpn;
            pfn_q[swp_slot] <= swp_pfn;
        end
    end

    assert_victim_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_en && swp_en));
    assert_flush_clears_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
endmodule

// File: rtl/xlate_dir_cache.sv
`timescale 1ns/1ps
module xlate_dir_cache #(
    parameter int unsigned N     = 4,
    parameter int unsigned TAG_W = 10,
    parameter int unsigned DTE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] srch_tag,
    output logic             hit,
    output logic [DTE_W-1:0] hit_dte,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DTE_W-1:0] fill_dte
);
    localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld_q;
    logic [TAG_W-1:0] tag_q [N];
    logic [DTE_W-1:0] dte_q [N];
    logic [PTR_W-1:0] next_q;
    logic [N-1:0]     match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == srch_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_dte = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_dte = dte_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            next_q <= '0;
        end else if (flush) begin
            vld_q  <= '0;
            next_q <= '0;
        end else if (fill_en) begin
            vld_q[next_q] <= 1'b1;
            next_q <= (next_q == PTR_W'(N - 1)) ? '0 : next_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[next_q] <= fill_tag;
            dte_q[next_q] <= fill_dte;
        end
    end

    assert_dir_unique_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    assert_flush_clears_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
endmodule

// File: rtl/page_xlate.sv
`timescale 1ns/1ps
module page_xlate
    import xlate_pkg::*;
#(
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned VICT_N = 8,
    parameter int unsigned DIR_N  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [ADDR_W-OFF_W-1:0] base_pfn,
    input  logic                    req_valid,
    input  logic [ADDR_W-OFF_W-1:0] req_vpn,
    output logic                    busy,
    output logic                    resp_valid,
    output logic [ADDR_W-OFF_W-1:0] resp_pfn,
    output logic [1:0]              resp_src,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_data
);
    localparam int unsigned VPN_W = ADDR_W - OFF_W;
    localparam int unsigned PFN_W = ADDR_W - OFF_W;
    localparam int unsigned TAG_W = VPN_W - IDX_W;
    localparam int unsigned DIR_W = OFF_W - 2;
    localparam int unsigned PT_W  = VPN_W - DIR_W;
    localparam int unsigned VP_W  = $clog2(VICT_N);

    walk_state_t state_q, state_d;

    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pt_base_q;
    logic             two_q;

    logic [VPN_W-1:0] cur_vpn;
    logic [IDX_W-1:0] m_idx;
    logic [TAG_W-1:0] m_want;
    logic             m_vld;
    logic [TAG_W-1:0] m_tag;
    logic [PFN_W-1:0] m_pfn;
    logic             main_hit;
    logic             v_hit;
    logic [VP_W-1:0]  v_slot;
    logic [PFN_W-1:0] v_pfn;
    logic             d_hit;
    logic [PFN_W-1:0] d_dte;
    logic             accept;
    logic             rsp_dir;
    logic             rsp_pte;
    logic             main_wr;
    logic             vic_swap;
    logic             vic_ins;
    logic [PFN_W-1:0] rsp_pfn_w;
    logic             unused_low;

    assign unused_low = ^mem_rsp_data[OFF_W-1:0];
    assign rsp_pfn_w  = mem_rsp_data[ADDR_W-1:OFF_W];

    assign cur_vpn  = (state_q == ST_IDLE) ? req_vpn : vpn_q;
    assign m_idx    = cur_vpn[IDX_W-1:0];
    assign m_want   = cur_vpn[VPN_W-1:IDX_W];
    assign main_hit = m_vld && (m_tag == m_want);
    assign accept   = (state_q == ST_IDLE) && req_valid && !flush;
    assign rsp_dir  = (state_q == ST_DIR) && mem_rsp_valid && !flush;
    assign rsp_pte  = (state_q == ST_PTE) && mem_rsp_valid && !flush;
    assign vic_swap = accept && !main_hit && v_hit;
    assign vic_ins  = rsp_pte && m_vld;
    assign main_wr  = vic_swap || rsp_pte;

    xlate_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_idx   (m_idx),
        .rd_valid (m_vld),
        .rd_tag   (m_tag),
        .rd_pfn   (m_pfn),
        .wr_en    (main_wr),
        .wr_idx   (m_idx),
        .wr_tag   (m_want),
        .wr_pfn   (rsp_pte ? rsp_pfn_w : v_pfn)
    );

    xlate_victim #(.N(VICT_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .srch_vpn  (cur_vpn),
        .hit       (v_hit),
        .hit_slot  (v_slot),
        .hit_pfn   (v_pfn),
        .ins_en    (vic_ins),
        .ins_vpn   ({m_tag, m_idx}),
        .ins_pfn   (m_pfn),
        .swp_en    (vic_swap),
        .swp_slot  (v_slot),
        .swp_valid (m_vld),
        .swp_vpn   ({m_tag, m_idx}),
        .swp_pfn   (m_pfn)
    );

    xlate_dir_cache #(.N(DIR_N), .TAG_W(DIR_W), .DTE_W(PFN_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .srch_tag (cur_vpn[VPN_W-1:PT_W]),
        .hit      (d_hit),
        .hit_dte  (d_dte),
        .fill_en  (rsp_dir),
        .fill_tag (vpn_q[VPN_W-1:PT_W]),
        .fill_dte (rsp_pfn_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !main_hit && !v_hit) state_d = d_hit ? ST_PTE : ST_DIR;
            ST_DIR:  if (mem_rsp_valid) state_d = ST_PTE;
            ST_PTE:  if (mem_rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;
    end

    // registered outputs and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q      <= '0;
            pt_base_q  <= '0;
            two_q      <= 1'b0;
            resp_valid <= 1'b0;
            resp_pfn   <= '0;
            resp_src   <= SRC_MAIN;
        end else begin
            resp_valid <= 1'b0;
            if (accept) begin
                vpn_q <= req_vpn;
                if (main_hit) begin
                    resp_valid <= 1'b1;
                    resp_pfn   <= m_pfn;
                    resp_src   <= SRC_MAIN;
                end else if (v_hit) begin
                    resp_valid <= 1'b1;
                    resp_pfn   <= v_pfn;
                    resp_src   <= SRC_VICTIM;
                end else begin
                    pt_base_q <= d_dte;
                    two_q     <= !d_hit;
                end
            end
            if (rsp_dir) pt_base_q <= rsp_pfn_w;
            if (rsp_pte) begin
                resp_valid <= 1'b1;
                resp_pfn   <= rsp_pfn_w;
                resp_src   <= two_q ? SRC_WALK2 : SRC_WALK1;
            end
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_DIR) || (state_q == ST_PTE);
    assign mem_req_addr  = (state_q == ST_DIR)
                         ? {base_pfn, vpn_q[VPN_W-1:PT_W], 2'b00}
                         : {pt_base_q, vpn_q[PT_W-1:0], 2'b00};

    assert_resp_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy);
    assert_busy_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_hit_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_src == SRC_MAIN)) |-> $past(req_valid && !busy));
    assert_no_read_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);
endmodule

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
    localparam logic [19:0] BASE = 20'h00100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic        busy;
    logic        resp_valid;
    logic [19:0] resp_pfn;
    logic [1:0]  resp_src;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_count = 0;

    typedef struct {
        logic [19:0] pfn;
        logic [1:0]  src;
        int          due;
        string       rq;
    } exp_t;
    exp_t q[$];

    page_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .base_pfn(BASE),
        .req_valid(req_valid), .req_vpn(req_vpn), .busy(busy),
        .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_src(resp_src),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
    endfunction

    function automatic logic [19:0] exp_pfn(input logic [19:0] vpn);
        logic [31:0] de, pe;
        de = mem_word({BASE, vpn[19:10], 2'b00});
        pe = mem_word({de[31:12], vpn[9:0], 2'b00});
        return pe[31:12];
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // memory model: reply on the second cycle of each request
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(mem_req_addr);
                    wait_cnt = 0;
                    rd_count++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "unexpected response", {12'h0, resp_pfn}, 32'h0);
                end else begin
                    e = q.pop_front();
                    check(resp_pfn == e.pfn, e.rq, "frame", {12'h0, resp_pfn}, {12'h0, e.pfn});
                    check(resp_src == e.src, e.rq, "source", {30'h0, resp_src}, {30'h0, e.src});
                    check(cyc == e.due, e.rq, "cycle", cyc, e.due);
                end
            end
        end
    end

    task automatic lookup(input logic [19:0] vpn, input logic [1:0] src, input string rq);
        int rd0;
        int lat;
        exp_t e;
        while (busy) @(negedge clk);
        lat = (src == 2'd3) ? 5 : (src == 2'd2) ? 3 : 1;
        rd0 = rd_count;
        e.pfn = exp_pfn(vpn);
        e.src = src;
        e.due = cyc + lat;
        e.rq  = rq;
        q.push_back(e);
        req_valid = 1'b1;
        req_vpn   = vpn;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        check(rd_count - rd0 == ((src == 2'd3) ? 2 : (src == 2'd2) ? 1 : 0), rq,
              "memory reads", rd_count - rd0, (src == 2'd3) ? 2 : (src == 2'd2) ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !resp_valid && !mem_req_valid, "R1", "reset outputs",
              {busy, resp_valid, mem_req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        lookup(20'h12345, 2'd3, "R7");          // full walk
        lookup(20'h12345, 2'd0, "R2");          // main hit
        lookup(20'h12346, 2'd2, "R8");          // same directory, other slot
        lookup(20'h12345, 2'd0, "R3");          // different slots coexist
        lookup(20'h13345, 2'd3, "R3");          // conflicting slot, new directory
        lookup(20'h12345, 2'd1, "R4");          // displaced page found in victim
        lookup(20'h12345, 2'd0, "R5");          // swapped into main
        lookup(20'h13345, 2'd1, "R5");          // displaced by swap, now in victim

        // R6: eight more displacements on slot 0x45
        for (int k = 0; k < 8; k++) begin
            if (k != 6) lookup(20'h12000 | 20'(k << 7) | 20'h45, 2'd2, "R6");
        end
        lookup(20'h13045, 2'd2, "R6");
        lookup(20'h13345, 2'd1, "R6");          // newer entry retained
        lookup(20'h12345, 2'd2, "R6");          // oldest entry discarded

        // R11: directory cache replacement in fill order
        lookup(20'h14010, 2'd3, "R11");
        lookup(20'h15011, 2'd3, "R11");
        lookup(20'h16012, 2'd3, "R11");
        lookup(20'h12013, 2'd3, "R11");
        lookup(20'h13014, 2'd3, "R11");
        lookup(20'h15015, 2'd2, "R11");

        // R9: busy window and ignored request
        while (busy) @(negedge clk);
        e.pfn = exp_pfn(20'h20020); e.src = 2'd3; e.due = cyc + 5; e.rq = "R9";
        q.push_back(e);
        req_valid = 1'b1; req_vpn = 20'h20020;
        @(negedge clk);
        check(busy, "R9", "busy after miss", {31'h0, busy}, 1);
        req_vpn = 20'h12346;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        check(!busy, "R9", "busy at response", {31'h0, busy}, 0);
        repeat (3) @(negedge clk);
        lookup(20'h12346, 2'd0, "R9");          // untouched by ignored request

        // R10: flush
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        lookup(20'h12346, 2'd3, "R10");
        lookup(20'h12345, 2'd2, "R10");
        lookup(20'h13345, 2'd3, "R10");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9", "pending responses", q.size(), 0);
        finish_run();
    end
endmodule